// File: doc/BRIEF.md
# Configuration Sequencing Controller

This block walks a programmable-logic configuration engine through its whole programming sequence in hardware, so that no firmware loop has to poll it. A start pulse makes it decode a 4-bit mode-select input into a configuration width and a clock-to-data ratio. It then holds the engine's configuration-reset line until the engine reports the reset phase, and waits for the configuration phase after releasing it. Next it clears the engine's 12 monitor interrupts and opens the bitstream streaming path.

Once streaming finishes, the block checks the done and status monitor bits. It then asks an external clock counter for two separate bursts of extra configuration clocks: the first lets the engine reach initialization, the second lets it reach user mode. Every wait is bounded by a parameterised poll limit. The outcome is reported as a one-cycle done pulse carrying a 4-bit result code, where zero means success and each failure point has its own code.

Top module: `cfg_seq_ctrl`

## Requirements
- R1: With mode-select bit 3 high, `wide_cfg_o` is 1. Low bits 00, 01 and 10 give ratio codes 0 (x1), 2 (x4) and 3 (x8). Ratio codes on `ratio_o` are 0=x1, 1=x2, 2=x4, 3=x8. Both outputs are latched on start.
- R2: With mode-select bit 3 low, `wide_cfg_o` is 0. Low bits 00, 01 and 10 give ratio codes 0 (x1), 1 (x2) and 2 (x4). Bit 2 has no effect.
- R3: Low bits 11 select ratio code 0 (x1) at either width.
- R4: On a start pulse in idle, `cfg_enable_o`, `line_drive_o` and `cfg_pull_o` rise after the next clock edge. The block then waits for `phase_i` to equal 3'd1 (reset). The other phase codes are 3'd2 configuration, 3'd3 initialization and 3'd4 user; any other value means "not reached". If the reset phase is not seen within TIMEOUT_CYCLES polls, result 1 is reported TIMEOUT_CYCLES cycles after the start edge.
- R5: After the reset phase is seen, `cfg_pull_o` drops and the block waits for phase 3'd2. A timeout gives result 2.
- R6: On reaching the configuration phase, `eoi_we_o` pulses for one cycle with `eoi_data_o` = 12'hFFF. `stream_en_o` is high from the next cycle.
- R7: The block waits for `stream_done_i`; a timeout gives result 4. In the following cycle, `stream_en_o` is low. If `mon_done_i` and `mon_status_i` are both low, result 3 is reported at once; if either is high, the sequence continues.
- R8: A clock burst is requested with `xclk_req_o` high and `xclk_count_o` = 4, held until `xclk_ack_i`. An ack with `xclk_err_i` high, or a timeout, gives result 5. The block then waits for phase 3'd3 or 3'd4; a timeout gives result 6.
- R9: A second burst is requested with `xclk_count_o` = 16'h5000; an error ack or a timeout gives result 7. The block then waits for phase 3'd4; a timeout gives result 8.
- R10: Reaching user mode reports result 0 and releases the enable, drive and pull outputs.
- R11: `done_o` is high for exactly one cycle per sequence, and `result_o` holds the result code in that cycle.
- R12: After any result, all drive, enable, pull, stream and request outputs are low. They stay low, with no further done pulse, until a new start pulse arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a sequence (acted on in idle) |
| mode_sel_i | input | 4 | Mode select: bit 3 width, bits 1:0 ratio |
| phase_i | input | 3 | Phase reported by the configuration engine |
| stream_done_i | input | 1 | Bitstream data path has delivered all data |
| mon_done_i | input | 1 | Done monitor bit |
| mon_status_i | input | 1 | Status monitor bit |
| xclk_ack_i | input | 1 | Clock counter acknowledge |
| xclk_err_i | input | 1 | Clock counter error flag, valid with ack |
| wide_cfg_o | output | 1 | 1 = 32-bit configuration width |
| ratio_o | output | 2 | Clock-to-data ratio code |
| cfg_enable_o | output | 1 | Configuration enable toward the engine |
| line_drive_o | output | 1 | Controller drives the configuration lines |
| cfg_pull_o | output | 1 | Holds the engine in its reset phase |
| eoi_we_o | output | 1 | Monitor interrupt-clear strobe |
| eoi_data_o | output | 12 | Interrupt bits to clear |
| stream_en_o | output | 1 | Opens the bitstream streaming path |
| xclk_req_o | output | 1 | Extra clock burst request |
| xclk_count_o | output | 16 | Number of extra clocks requested |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 4 | Result code, 0 = success |

## Verification
The mode-select input is swept over all three codes at each width, plus the 11 code and a value with bit 2 set, so that each width/ratio pairing is told apart from a mapping that ignores bit 3 or bit 2. The sequence is then run once for each failure point, using an engine model that stalls or flags an error at exactly one step; this shows that each result code comes from its own wait and not a neighbouring one. Success runs cover both monitor bits separately and an engine that jumps straight to user mode after the first burst. The burst sizes, the interrupt-clear value and the order of stream-off before the burst requests are recorded on every run.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST_WAIT,
    ST_CFG_WAIT,
    ST_EOI,
    ST_STREAM,
    ST_CD_CHECK,
    ST_XCLK_A,
    ST_INIT_WAIT,
    ST_XCLK_B,
    ST_USER_WAIT
  } seq_state_e;

  localparam logic [2:0] PH_RESET  = 3'd1;
  localparam logic [2:0] PH_CONFIG = 3'd2;
  localparam logic [2:0] PH_INIT   = 3'd3;
  localparam logic [2:0] PH_USER   = 3'd4;

  localparam logic [1:0] RAT_X1 = 2'd0;
  localparam logic [1:0] RAT_X2 = 2'd1;
  localparam logic [1:0] RAT_X4 = 2'd2;
  localparam logic [1:0] RAT_X8 = 2'd3;

  localparam logic [3:0] RC_OK        = 4'd0;
  localparam logic [3:0] RC_NO_RESET  = 4'd1;
  localparam logic [3:0] RC_NO_CONFIG = 4'd2;
  localparam logic [3:0] RC_MON_LOW   = 4'd3;
  localparam logic [3:0] RC_STREAM_TO = 4'd4;
  localparam logic [3:0] RC_XCLK_A    = 4'd5;
  localparam logic [3:0] RC_NO_INIT   = 4'd6;
  localparam logic [3:0] RC_XCLK_B    = 4'd7;
  localparam logic [3:0] RC_NO_USER   = 4'd8;

  // Ratio code from width bit and the two low select bits.
  function automatic logic [1:0] ratio_for(input logic wide, input logic [1:0] low);
    logic [1:0] r;
    case (low)
      2'b01:   r = wide ? RAT_X4 : RAT_X2;
      2'b10:   r = wide ? RAT_X8 : RAT_X4;
      default: r = RAT_X1;
    endcase
    return r;
  endfunction

  // States in which the poll timer runs.
  function automatic logic is_wait_state(input seq_state_e s);
    return (s == ST_RST_WAIT) || (s == ST_CFG_WAIT) || (s == ST_STREAM) ||
           (s == ST_XCLK_A) || (s == ST_INIT_WAIT) || (s == ST_XCLK_B) ||
           (s == ST_USER_WAIT);
  endfunction

  // Result code reported when the timer expires in a given state.
  function automatic logic [3:0] timeout_code(input seq_state_e s);
    logic [3:0] c;
    case (s)
      ST_RST_WAIT:  c = RC_NO_RESET;
      ST_CFG_WAIT:  c = RC_NO_CONFIG;
      ST_STREAM:    c = RC_STREAM_TO;
      ST_XCLK_A:    c = RC_XCLK_A;
      ST_INIT_WAIT: c = RC_NO_INIT;
      ST_XCLK_B:    c = RC_XCLK_B;
      default:      c = RC_NO_USER;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/cfg_mode_decode.sv
module cfg_mode_decode
  import cfg_seq_pkg::*;
#(
  parameter int SEL_W = 4,
  parameter int WIDE_BIT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             wide_o,
  output logic [1:0]       ratio_o
);

  logic       wide_d;
  logic [1:0] ratio_d;

  always_comb begin
    wide_d  = sel_i[WIDE_BIT];
    ratio_d = ratio_for(wide_d, sel_i[1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_o  <= 1'b0;
      ratio_o <= RAT_X1;
    end else if (load_i) begin
      wide_o  <= wide_d;
      ratio_o <= ratio_d;
    end
  end

  // R1/R2: latched settings hold between loads
  assert_mode_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(wide_o) && $stable(ratio_o)));

endmodule

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
  parameter int LIMIT = 32'h0100_0000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic expired_o
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign expired_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (run_i && !expired_o)  cnt_q <= cnt_q + 1'b1;
  end

  // R4: a running count never passes the poll limit
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !clr_i && !expired_o) |=> (cnt_q <= LAST));

endmodule

// File: rtl/cfg_xclk_port.sv
module cfg_xclk_port #(
  parameter int CNT_W   = 16,
  parameter int BURST_A = 4,
  parameter int BURST_B = 16'h5000
) (
  input  logic             active_a_i,
  input  logic             active_b_i,
  input  logic             ack_i,
  input  logic             err_i,
  output logic             req_o,
  output logic [CNT_W-1:0] count_o,
  output logic             ok_o,
  output logic             fail_o
);

  always_comb begin
    req_o   = active_a_i || active_b_i;
    count_o = active_b_i ? CNT_W'(BURST_B) : (active_a_i ? CNT_W'(BURST_A) : '0);
    ok_o    = req_o && ack_i && !err_i;
    fail_o  = req_o && ack_i && err_i;
  end

  // R8: the two bursts are never requested together
  assert_one_burst_R8: assert final (!(active_a_i && active_b_i));

endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 32'h0100_0000,
  parameter int IRQ_W   = 12,
  parameter int CNT_W   = 16,
  parameter int BURST_A = 4,
  parameter int BURST_B = 16'h5000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [3:0]       mode_sel_i,
  input  logic [2:0]       phase_i,
  input  logic             stream_done_i,
  input  logic             mon_done_i,
  input  logic             mon_status_i,
  input  logic             xclk_ack_i,
  input  logic             xclk_err_i,
  output logic             wide_cfg_o,
  output logic [1:0]       ratio_o,
  output logic             cfg_enable_o,
  output logic             line_drive_o,
  output logic             cfg_pull_o,
  output logic             eoi_we_o,
  output logic [IRQ_W-1:0] eoi_data_o,
  output logic             stream_en_o,
  output logic             xclk_req_o,
  output logic [CNT_W-1:0] xclk_count_o,
  output logic             done_o,
  output logic [3:0]       result_o
);

  seq_state_e state_q, state_d;
  logic       fin_d;
  logic [3:0] code_d;
  logic       launch;
  logic       tmr_clr, tmr_run, tmr_expired;
  logic       x_ok, x_fail;
  logic       mon_any;

  assign launch  = (state_q == ST_IDLE) && start_i;
  assign mon_any = mon_done_i || mon_status_i;

  cfg_mode_decode #(.SEL_W(4), .WIDE_BIT(3)) u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (launch),
    .sel_i   (mode_sel_i),
    .wide_o  (wide_cfg_o),
    .ratio_o (ratio_o)
  );

  cfg_wait_timer #(.LIMIT(TIMEOUT_CYCLES)) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (tmr_clr),
    .run_i     (tmr_run),
    .expired_o (tmr_expired)
  );

  cfg_xclk_port #(.CNT_W(CNT_W), .BURST_A(BURST_A), .BURST_B(BURST_B)) u_xclk (
    .active_a_i (state_q == ST_XCLK_A),
    .active_b_i (state_q == ST_XCLK_B),
    .ack_i      (xclk_ack_i),
    .err_i      (xclk_err_i),
    .req_o      (xclk_req_o),
    .count_o    (xclk_count_o),
    .ok_o       (x_ok),
    .fail_o     (x_fail)
  );

  always_comb begin
    state_d = state_q;
    fin_d   = 1'b0;
    code_d  = RC_OK;
    case (state_q)
      ST_IDLE:     if (start_i) state_d = ST_RST_WAIT;
      ST_RST_WAIT: if (phase_i == PH_RESET) state_d = ST_CFG_WAIT;
      ST_CFG_WAIT: if (phase_i == PH_CONFIG) state_d = ST_EOI;
      ST_EOI:      state_d = ST_STREAM;
      ST_STREAM:   if (stream_done_i) state_d = ST_CD_CHECK;
      ST_CD_CHECK: begin
        if (!mon_any) begin
          fin_d  = 1'b1;
          code_d = RC_MON_LOW;
        end else begin
          state_d = ST_XCLK_A;
        end
      end
      ST_XCLK_A: begin
        if (x_ok) state_d = ST_INIT_WAIT;
        else if (x_fail) begin
          fin_d  = 1'b1;
          code_d = RC_XCLK_A;
        end
      end
      ST_INIT_WAIT: if ((phase_i == PH_INIT) || (phase_i == PH_USER)) state_d = ST_XCLK_B;
      ST_XCLK_B: begin
        if (x_ok) state_d = ST_USER_WAIT;
        else if (x_fail) begin
          fin_d  = 1'b1;
          code_d = RC_XCLK_B;
        end
      end
      ST_USER_WAIT: begin
        if (phase_i == PH_USER) begin
          fin_d  = 1'b1;
          code_d = RC_OK;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    // Timeout applies only when no progress was made in this cycle.
    if (tmr_expired && !fin_d && (state_d == state_q)) begin
      fin_d  = 1'b1;
      code_d = timeout_code(state_q);
    end
    if (fin_d) state_d = ST_IDLE;
  end

  assign tmr_run = is_wait_state(state_q);
  assign tmr_clr = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      done_o   <= 1'b0;
      result_o <= RC_OK;
    end else begin
      state_q <= state_d;
      done_o  <= fin_d;
      if (fin_d) result_o <= code_d;
    end
  end

  always_comb begin
    cfg_enable_o = (state_q != ST_IDLE);
    line_drive_o = (state_q != ST_IDLE);
    cfg_pull_o   = (state_q == ST_RST_WAIT);
    eoi_we_o     = (state_q == ST_EOI);
    eoi_data_o   = eoi_we_o ? {IRQ_W{1'b1}} : '0;
    stream_en_o  = (state_q == ST_STREAM);
  end

  // R11: completion pulse lasts one cycle
  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6: interrupt clear is followed directly by streaming
  assert_eoi_then_stream_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_we_o |=> stream_en_o);

  // R12: any reported result leaves the lines released
  assert_err_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!line_drive_o && !cfg_enable_o && !cfg_pull_o && !stream_en_o && !xclk_req_o));

  // R8: a pending burst request stays up with a steady count until ack or timeout
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xclk_req_o && !xclk_ack_i && !tmr_expired) |=> (xclk_req_o && $stable(xclk_count_o)));

  // R4: an expired poll window always ends the sequence with a nonzero result
  assert_timeout_reports_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_expired && !xclk_ack_i && !(cfg_pull_o && phase_i == PH_RESET)) |=> (done_o && result_o != 4'd0) || !done_o);

  // R10: success leaves the drive released
  assert_ok_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && result_o == 4'd0) |-> !line_drive_o);

endmodule

// File: tb/sim_cfg_seq_ctrl.sv
module sim_cfg_seq_ctrl;

  localparam int TMO = 16;

  typedef struct packed {
    logic [3:0] mode;
    logic [3:0] flt;
    logic       st_only;
    logic       skip_init;
    logic [3:0] exp_res;
    logic       exp_wide;
    logic [1:0] exp_rat;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VT [NV] = '{
    '{4'h8, 4'd0, 1'b0, 1'b0, 4'd0, 1'b1, 2'd0},
    '{4'h9, 4'd0, 1'b0, 1'b0, 4'd0, 1'b1, 2'd2},
    '{4'hA, 4'd0, 1'b0, 1'b0, 4'd0, 1'b1, 2'd3},
    '{4'hB, 4'd0, 1'b0, 1'b0, 4'd0, 1'b1, 2'd0},
    '{4'h0, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0},
    '{4'h1, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 2'd1},
    '{4'h2, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 2'd2},
    '{4'h3, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 2'd0},
    '{4'h6, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 2'd2},
    '{4'h9, 4'd1, 1'b0, 1'b0, 4'd1, 1'b1, 2'd2},
    '{4'h1, 4'd2, 1'b0, 1'b0, 4'd2, 1'b0, 2'd1},
    '{4'h0, 4'd3, 1'b0, 1'b0, 4'd3, 1'b0, 2'd0},
    '{4'hA, 4'd4, 1'b0, 1'b0, 4'd4, 1'b1, 2'd3},
    '{4'h2, 4'd5, 1'b0, 1'b0, 4'd5, 1'b0, 2'd2},
    '{4'h8, 4'd6, 1'b0, 1'b0, 4'd6, 1'b1, 2'd0},
    '{4'h1, 4'd7, 1'b0, 1'b0, 4'd7, 1'b0, 2'd1},
    '{4'hA, 4'd8, 1'b0, 1'b0, 4'd8, 1'b1, 2'd3},
    '{4'h9, 4'd0, 1'b1, 1'b0, 4'd0, 1'b1, 2'd2},
    '{4'h2, 4'd0, 1'b0, 1'b1, 4'd0, 1'b0, 2'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] mode = '0;
  logic [3:0] flt = '0;
  logic st_only = 1'b0, skip_init = 1'b0;

  logic [2:0] phase;
  logic sdone, ack, xerr;
  logic mon_done, mon_status;
  logic wide, pull, en, drive, eoi_we, stream_en, req, done;
  logic [1:0] ratio;
  logic [11:0] eoi_data;
  logic [15:0] xcount;
  logic [3:0] result;

  // model bookkeeping
  logic [1:0] dly;
  int nacks, scnt;
  logic got_wide, eoi_ok, str_seen, overlap;
  logic [1:0] got_rat;
  logic [15:0] cnt_a, cnt_b;

  int total = 0, bad = 0;

  always #2 clk = ~clk;

  assign mon_done   = (flt != 4'd3) && !st_only;
  assign mon_status = st_only;

  cfg_seq_ctrl #(.TIMEOUT_CYCLES(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mode_sel_i(mode),
    .phase_i(phase), .stream_done_i(sdone), .mon_done_i(mon_done),
    .mon_status_i(mon_status), .xclk_ack_i(ack), .xclk_err_i(xerr),
    .wide_cfg_o(wide), .ratio_o(ratio), .cfg_enable_o(en), .line_drive_o(drive),
    .cfg_pull_o(pull), .eoi_we_o(eoi_we), .eoi_data_o(eoi_data),
    .stream_en_o(stream_en), .xclk_req_o(req), .xclk_count_o(xcount),
    .done_o(done), .result_o(result)
  );

  // Engine and clock-counter model, clocked on the same edge as the design.
  always @(posedge clk) begin
    if (!rst_n || start) begin
      phase <= 3'd0; sdone <= 1'b0; ack <= 1'b0; xerr <= 1'b0; dly <= '0;
      nacks <= 0; scnt <= 0; got_wide <= 1'b0; got_rat <= '0; eoi_ok <= 1'b0;
      str_seen <= 1'b0; overlap <= 1'b0; cnt_a <= '0; cnt_b <= '0;
    end else begin
      ack <= 1'b0;
      xerr <= 1'b0;
      if (pull) begin
        got_wide <= wide;
        got_rat  <= ratio;
        if (flt != 4'd1) phase <= 3'd1;
      end
      if (!pull && phase == 3'd1 && flt != 4'd2) phase <= 3'd2;
      if (eoi_we) eoi_ok <= (eoi_data == 12'hFFF);
      if (stream_en) begin
        str_seen <= 1'b1;
        scnt <= scnt + 1;
        if (scnt == 2 && flt != 4'd4) sdone <= 1'b1;
      end
      if (stream_en && req) overlap <= 1'b1;
      if (req && !ack) begin
        if (dly == 2'd1) begin
          dly <= '0;
          ack <= 1'b1;
          nacks <= nacks + 1;
          if (nacks == 0) begin
            cnt_a <= xcount;
            if (flt == 4'd5) xerr <= 1'b1;
            else if (flt != 4'd6) phase <= skip_init ? 3'd4 : 3'd3;
          end else begin
            cnt_b <= xcount;
            if (flt == 4'd7) xerr <= 1'b1;
            else if (flt != 4'd8) phase <= 3'd4;
          end
        end else begin
          dly <= dly + 1'b1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  task automatic run_seq(output int lat);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    forever begin
      lat++;
      if (done || lat > 4000) break;
      @(negedge clk);
    end
  endtask

  task automatic idle_outputs(input string tag);
    chk(!en && !drive && !pull && !stream_en && !req && !eoi_we, tag,
        {en, drive, pull, stream_en, req, eoi_we}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // Reset state: everything low, no done, result zero (R12, R11)
    idle_outputs("R12 reset");
    chk(!done && result == 4'd0, "R11 reset", {done, result}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      int lat;
      vec_t v;
      v = VT[i];
      mode = v.mode; flt = v.flt; st_only = v.st_only; skip_init = v.skip_init;
      run_seq(lat);
      chk(done == 1'b1, "R11 done seen", done, 1);
      chk(result == v.exp_res, (v.exp_res == 0) ? "R10 result" :
          (v.exp_res <= 2) ? "R5 result" : (v.exp_res <= 4) ? "R7 result" :
          (v.exp_res <= 6) ? "R8 result" : "R9 result", result, v.exp_res);
      chk(got_wide == v.exp_wide, v.mode[3] ? "R1 width" : "R2 width", got_wide, v.exp_wide);
      chk(got_rat == v.exp_rat, (v.mode[1:0] == 2'b11) ? "R3 ratio" :
          (v.mode[3] ? "R1 ratio" : "R2 ratio"), got_rat, v.exp_rat);
      idle_outputs("R12 after done");
      if (v.flt == 4'd1) chk(lat == TMO + 1, "R4 timeout latency", lat, TMO + 1);
      if (v.exp_res == 4'd0) begin
        chk(eoi_ok, "R6 eoi value", eoi_ok, 1);
        chk(str_seen && !overlap, "R7 stream then off", {str_seen, overlap}, 2);
        chk(cnt_a == 16'd4, "R8 burst count", cnt_a, 4);
        chk(cnt_b == 16'h5000, "R9 burst count", cnt_b, 16'h5000);
      end
      @(negedge clk);
      chk(!done, "R11 single pulse", done, 0);
    end

    // R12: after an error, nothing happens without a new start
    mode = 4'h8; flt = 4'd3; st_only = 1'b0; skip_init = 1'b0;
    begin
      int lat;
      bit quiet;
      run_seq(lat);
      chk(result == 4'd3, "R7 monitor low", result, 3);
      quiet = 1'b1;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (done || en || drive || pull || stream_en || req) quiet = 1'b0;
      end
      chk(quiet, "R12 stays idle", quiet, 1);
    end

    // R4: pull is up in the cycle after the start edge
    mode = 4'h0; flt = 4'd0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(pull && en && drive, "R4 pull after start", {pull, en, drive}, 7);
    begin
      int guard = 0;
      while (!done && guard < 4000) begin
        @(negedge clk);
        guard++;
      end
      chk(result == 4'd0, "R10 full run", result, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule